// File: doc/BRIEF.md
# Delayed-Branch Next-PC Unit

This block produces the fetch address sequence for a 32-bit RISC pipeline that has one branch delay slot. It holds the program counter. Each cycle it sees the instruction word at that address and the two source register values read for it. From these it chooses the next fetch address. A control transfer does not redirect fetch straight away. The instruction after it, the delay slot, is always fetched. The redirect to the target takes effect on the fetch that follows the slot.

Linking transfers request a register write of the return address. The return address is the transfer's own address plus 8. The "likely" branch forms raise a squash flag while their delay-slot instruction is on the input, but only when the branch is not taken. A transfer found in a live delay slot is flagged and has no effect. A low `advance` freezes the unit for a pipeline stall.

Top module: `npc_unit`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `fetchPc` equals `RESET_PC` (default 0). `linkWe`, `annulSlot` and `slotFault` are all low.
- R2: A word that is not a control transfer gives `nextPc = fetchPc + 4`. On each cycle with `advance` high, `fetchPc` takes the value `nextPc` had in the cycle before.
- R3: A taken PC-relative branch at address P does not change the next fetch, which is P+4. While the slot at P+4 is on the input, `nextPc` = (P+4) + (sign-extended `instr[15:0]` shifted left by 2).
- R4: An absolute jump (`instr[31:26]` = 000010 jump, 000011 jump-and-link) at address P redirects after its slot to {(P+4)[31:28], `instr[25:0]`, 2'b00}.
- R5: A register jump (`instr[31:26]` = 000000 with `instr[5:0]` = 001000 plain, 001001 linking) redirects after its slot to `rsVal`.
- R6: The two-register and zero-compare branches are decoded from `instr[31:26]`: 000100 rs==rt, 000101 rs!=rt, 000110 rs<=0 signed, 000111 rs>0 signed. The same values with bit 4 set (010100..010111) are the likely forms.
- R7: `instr[31:26]` = 000001 is the zero-compare group, and a member is a transfer only when `instr[19:18]` = 00. `instr[16]` picks rs>=0 (1) or rs<0 (0), `instr[17]` makes it likely and `instr[20]` makes it link. Other members fall through as non-transfers.
- R8: A linking transfer in a non-slot cycle with `advance` high raises `linkWe` whether or not it is taken, with `linkAddr` = its address + 8. `linkReg` is 31, except for the linking register jump, which uses `instr[15:11]`.
- R9: A likely branch that is not taken raises `annulSlot` for the whole cycle its slot instruction is on the input. That slot instruction neither links nor faults nor redirects, and fetch goes on at slot+4. Taken likely branches and ordinary branches never raise `annulSlot`.
- R10: A transfer sitting in a non-annulled delay slot raises `slotFault`, does not link, and is ignored. Fetch still goes to the target that was pending, or to slot+4 if nothing was pending.
- R11: With `advance` low, `linkWe` stays low and the PC and slot state hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| advance | input | 1 | Pipeline moves this cycle |
| instr | input | 32 | Instruction word at `fetchPc` |
| rsVal | input | 32 | Value of the rs source register |
| rtVal | input | 32 | Value of the rt source register |
| fetchPc | output | 32 | Address of the instruction on `instr` |
| nextPc | output | 32 | Address to fetch next |
| linkWe | output | 1 | Return-address write request |
| linkReg | output | 5 | Destination register of the link write |
| linkAddr | output | 32 | Return address (transfer address + 8) |
| annulSlot | output | 1 | Squash the current delay-slot instruction |
| slotFault | output | 1 | Transfer found in a live delay slot |

## Verification
The bench goes after the timing of the redirect. If the unit jumped straight away, the slot address would never show up on `fetchPc`. If it dropped the pending target, the slot would be followed by slot+4. Branches in the zero-compare group are tried not taken but linking, and also on the register values where signed and unsigned compares differ. A unit that linked only on taken branches, or that compared rs as unsigned, would give the wrong link or the wrong PC. A transfer is placed in an annulled slot and another in a live slot; this catches a unit that faults on squashed slots or lets a slot transfer replace the pending target. Jumps run from a high address region to check that the top four bits are kept, and a group member that is not a transfer checks that it does not open a slot.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    TGT_REL = 2'd0,
    TGT_ABS = 2'd1,
    TGT_REG = 2'd2
  } tgtSel_e;

  typedef struct packed {
    logic    loadPend;
    logic    usePend;
    tgtSel_e tgtSel;
  } npcStrobe_t;
endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
#(
  parameter int LINK_REG = 31
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       advance,
  input  logic [5:0] opField,
  input  logic [4:0] rtSel,
  input  logic [4:0] rdSel,
  input  logic [5:0] funct,
  input  logic       rsEq,
  input  logic       rsNeg,
  input  logic       rsZero,
  output npcStrobe_t strobe,
  output logic       linkWe,
  output logic [4:0] linkReg,
  output logic       annulSlot,
  output logic       slotFault
);
  logic    isXfer, condTrue, likely, doLink, linkToRd;
  tgtSel_e tgtSel;
  logic    inSlot, redirectPend, annulPend;
  logic    liveXfer;

  // Decode of transfer class and condition
  always_comb begin
    isXfer   = 1'b0;
    condTrue = 1'b0;
    likely   = 1'b0;
    doLink   = 1'b0;
    linkToRd = 1'b0;
    tgtSel   = TGT_REL;
    unique casez (opField)
      6'b000000: begin
        if (funct == 6'b001000 || funct == 6'b001001) begin
          isXfer   = 1'b1;
          condTrue = 1'b1;
          tgtSel   = TGT_REG;
          doLink   = funct[0];
          linkToRd = funct[0];
        end
      end
      6'b000001: begin
        if (rtSel[3:2] == 2'b00) begin
          isXfer   = 1'b1;
          condTrue = rtSel[0] ? !rsNeg : rsNeg;
          likely   = rtSel[1];
          doLink   = rtSel[4];
        end
      end
      6'b00001?: begin
        isXfer   = 1'b1;
        condTrue = 1'b1;
        tgtSel   = TGT_ABS;
        doLink   = opField[0];
      end
      6'b0?01??: begin
        isXfer = 1'b1;
        likely = opField[4];
        unique case (opField[1:0])
          2'b00: condTrue = rsEq;
          2'b01: condTrue = !rsEq;
          2'b10: condTrue = rsNeg || rsZero;
          default: condTrue = !rsNeg && !rsZero;
        endcase
      end
      default: ;
    endcase
  end

  assign liveXfer        = !inSlot && isXfer;
  assign strobe.loadPend = advance && liveXfer && condTrue;
  assign strobe.usePend  = redirectPend;
  assign strobe.tgtSel   = tgtSel;
  assign linkWe          = advance && liveXfer && doLink;
  assign linkReg         = linkToRd ? rdSel : 5'(LINK_REG);
  assign annulSlot       = annulPend;
  assign slotFault       = inSlot && !annulPend && isXfer;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inSlot       <= 1'b0;
      redirectPend <= 1'b0;
      annulPend    <= 1'b0;
    end else if (advance) begin
      inSlot       <= liveXfer;
      redirectPend <= liveXfer && condTrue;
      annulPend    <= liveXfer && likely && !condTrue;
    end
  end

  // R8: the cycle after a link request is a delay slot, so it cannot link again
  p_link_once_r8: assert property (@(posedge clk) disable iff (!rstN)
    linkWe |=> !linkWe);
  // R10: a faulting slot transfer never writes a link
  p_fault_nolink_r10: assert property (@(posedge clk) disable iff (!rstN)
    slotFault |-> !linkWe);
  // R9: an annulled slot never comes with a pending redirect
  p_annul_noredir_r9: assert property (@(posedge clk) disable iff (!rstN)
    annulSlot |-> !strobe.usePend);
  // R11: a stall holds the slot state
  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !advance |=> $stable(annulSlot));
endmodule

// File: rtl/npc_dpath.sv
module npc_dpath
  import npc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            advance,
  input  npcStrobe_t      strobe,
  input  logic [25:0]     jumpField,
  input  logic [XLEN-1:0] rsVal,
  input  logic [XLEN-1:0] rtVal,
  output logic            rsEq,
  output logic            rsNeg,
  output logic            rsZero,
  output logic [XLEN-1:0] fetchPc,
  output logic [XLEN-1:0] nextPc,
  output logic [XLEN-1:0] linkAddr
);
  localparam int OFF_W  = 16;
  localparam int IDX_W  = 26;
  localparam int SEXT_W = XLEN - OFF_W - 2;
  localparam int HIGH_W = XLEN - IDX_W - 2;

  logic [XLEN-1:0] slotPc, offExt, relTgt, absTgt, tgtVal, pendTarget;

  assign rsEq   = (rsVal == rtVal);
  assign rsNeg  = rsVal[XLEN-1];
  assign rsZero = (rsVal == '0);

  assign slotPc   = fetchPc + XLEN'(4);
  assign linkAddr = fetchPc + XLEN'(8);
  assign offExt   = {{SEXT_W{jumpField[OFF_W-1]}}, jumpField[OFF_W-1:0], 2'b00};
  assign relTgt   = slotPc + offExt;
  assign absTgt   = {slotPc[XLEN-1 -: HIGH_W], jumpField, 2'b00};

  always_comb begin
    unique case (strobe.tgtSel)
      TGT_ABS: tgtVal = absTgt;
      TGT_REG: tgtVal = rsVal;
      default: tgtVal = relTgt;
    endcase
  end

  assign nextPc = strobe.usePend ? pendTarget : slotPc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchPc    <= XLEN'(RESET_PC);
      pendTarget <= '0;
    end else begin
      if (advance) fetchPc <= nextPc;
      if (strobe.loadPend) pendTarget <= tgtVal;
    end
  end

  // R2: without a pending redirect, fetch moves on by one word
  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !strobe.usePend) |=> (fetchPc == $past(fetchPc) + XLEN'(4)));
  // R3: a pending redirect lands on the captured target after the slot
  p_redirect_r3: assert property (@(posedge clk) disable iff (!rstN)
    (advance && strobe.usePend) |=> (fetchPc == $past(pendTarget)));
  // R11: a stall holds the PC
  p_stall_pc_r11: assert property (@(posedge clk) disable iff (!rstN)
    !advance |=> $stable(fetchPc));
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'h0,
  parameter int          LINK_REG = 31
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            advance,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rsVal,
  input  logic [XLEN-1:0] rtVal,
  output logic [XLEN-1:0] fetchPc,
  output logic [XLEN-1:0] nextPc,
  output logic            linkWe,
  output logic [4:0]      linkReg,
  output logic [XLEN-1:0] linkAddr,
  output logic            annulSlot,
  output logic            slotFault
);
  npcStrobe_t strobe;
  logic       rsEq, rsNeg, rsZero;

  npc_ctrl #(.LINK_REG(LINK_REG)) u_ctrl (
    .clk(clk), .rstN(rstN), .advance(advance),
    .opField(instr[31:26]), .rtSel(instr[20:16]), .rdSel(instr[15:11]),
    .funct(instr[5:0]), .rsEq(rsEq), .rsNeg(rsNeg), .rsZero(rsZero),
    .strobe(strobe), .linkWe(linkWe), .linkReg(linkReg),
    .annulSlot(annulSlot), .slotFault(slotFault)
  );

  npc_dpath #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_dpath (
    .clk(clk), .rstN(rstN), .advance(advance), .strobe(strobe),
    .jumpField(instr[25:0]), .rsVal(rsVal), .rtVal(rtVal),
    .rsEq(rsEq), .rsNeg(rsNeg), .rsZero(rsZero),
    .fetchPc(fetchPc), .nextPc(nextPc), .linkAddr(linkAddr)
  );
endmodule

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        advance = 1'b0;
  logic [31:0] instr = '0, rsVal = '0, rtVal = '0;
  logic [31:0] fetchPc, nextPc, linkAddr;
  logic        linkWe, annulSlot, slotFault;
  logic [4:0]  linkReg;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_unit u_npc_unit (
    .clk(clk), .rstN(rstN), .advance(advance), .instr(instr),
    .rsVal(rsVal), .rtVal(rtVal), .fetchPc(fetchPc), .nextPc(nextPc),
    .linkWe(linkWe), .linkReg(linkReg), .linkAddr(linkAddr),
    .annulSlot(annulSlot), .slotFault(slotFault)
  );

  typedef struct {
    logic [31:0] pc, npc, laddr;
    logic        lwe, ann, flt;
    logic [4:0]  lreg;
    string       tag;
  } expItem_t;

  expItem_t scoreQ[$];

  // reference state kept from the requirements
  logic [31:0] mPc = '0, mTgt = '0;
  logic        mSlot = 1'b0, mPend = 1'b0, mAnnul = 1'b0;

  function automatic logic [31:0] encI(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] encJ(input logic [5:0] op, input logic [25:0] idx);
    return {op, idx};
  endfunction
  function automatic logic [31:0] encR(input logic [4:0] rs, input logic [4:0] rd,
                                       input logic [5:0] fn);
    return {6'd0, rs, 5'd0, rd, 5'd0, fn};
  endfunction

  task automatic step(input logic [31:0] ins, input logic [31:0] a,
                      input logic [31:0] b, input logic adv, input string tag);
    expItem_t e;
    logic [5:0] op;
    logic [4:0] rtf;
    logic       isX, cond, lik, lnk;
    logic [4:0] lr;
    logic [31:0] tgt, slot;
    @(negedge clk);
    instr = ins; rsVal = a; rtVal = b; advance = adv;
    op = ins[31:26]; rtf = ins[20:16];
    isX = 0; cond = 0; lik = 0; lnk = 0; lr = 5'd31;
    slot = mPc + 32'd4;
    tgt = slot + {{14{ins[15]}}, ins[15:0], 2'b00};
    if (op == 6'd0 && (ins[5:0] == 6'b001000 || ins[5:0] == 6'b001001)) begin
      isX = 1; cond = 1; tgt = a;
      if (ins[0]) begin lnk = 1; lr = ins[15:11]; end
    end else if (op == 6'd1 && rtf[3:2] == 2'b00) begin
      isX = 1; lik = rtf[1]; lnk = rtf[4];
      cond = rtf[0] ? ($signed(a) >= 0) : ($signed(a) < 0);
    end else if (op == 6'd2 || op == 6'd3) begin
      isX = 1; cond = 1; lnk = op[0];
      tgt = {slot[31:28], ins[25:0], 2'b00};
    end else if (op[5] == 1'b0 && op[3:2] == 2'b01) begin
      isX = 1; lik = op[4];
      case (op[1:0])
        2'b00: cond = (a == b);
        2'b01: cond = (a != b);
        2'b10: cond = ($signed(a) <= 0);
        default: cond = ($signed(a) > 0);
      endcase
    end
    e.pc = mPc; e.tag = tag; e.laddr = mPc + 32'd8; e.lreg = lr;
    e.npc = mPend ? mTgt : slot;
    e.ann = mAnnul;
    e.flt = mSlot && !mAnnul && isX;
    e.lwe = !mSlot && isX && lnk && adv;
    scoreQ.push_back(e);
    if (adv) begin
      mPc = e.npc;
      if (mSlot) begin
        mSlot = 0; mPend = 0; mAnnul = 0;
      end else begin
        mSlot = isX; mPend = isX && cond; mAnnul = isX && lik && !cond;
        if (isX && cond) mTgt = tgt;
      end
    end
  endtask

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // monitor: pops expected items and compares away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (scoreQ.size() > 0) begin
        expItem_t e;
        e = scoreQ.pop_front();
        cmp(e.tag, "fetchPc", fetchPc, e.pc);
        cmp(e.tag, "nextPc", nextPc, e.npc);
        cmp(e.tag, "linkWe", {31'd0, linkWe}, {31'd0, e.lwe});
        if (e.lwe) begin
          cmp(e.tag, "linkReg", {27'd0, linkReg}, {27'd0, e.lreg});
          cmp(e.tag, "linkAddr", linkAddr, e.laddr);
        end
        cmp(e.tag, "annulSlot", {31'd0, annulSlot}, {31'd0, e.ann});
        cmp(e.tag, "slotFault", {31'd0, slotFault}, {31'd0, e.flt});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  localparam logic [31:0] NOP = 32'h0;
  localparam logic [31:0] NEG5 = 32'hFFFF_FFFB;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset value while reset is still held
    #(CLK_PERIOD/4);
    cmp("R1", "fetchPc in reset", fetchPc, 32'h0);
    cmp("R1", "outputs in reset", {29'd0, linkWe, annulSlot, slotFault}, 32'h0);
    rstN = 1'b1;
    step(NOP, 0, 0, 1'b0, "R1");
    step(NOP, 0, 0, 1'b1, "R2");
    step(NOP, 0, 0, 1'b1, "R2");
    // R11: stalled link instruction does nothing
    step(encJ(6'b000011, 26'h40), 0, 0, 1'b0, "R11");
    step(encJ(6'b000011, 26'h40), 0, 0, 1'b0, "R11");
    // R4 / R8: jump-and-link at 0x8 -> 0x100
    step(encJ(6'b000011, 26'h40), 0, 0, 1'b1, "R8");
    step(NOP, 0, 0, 1'b1, "R4");
    // R3 / R6: equal branch taken with negative offset
    step(encI(6'b000100, 5'd1, 5'd2, 16'hFFFC), 32'h55, 32'h55, 1'b1, "R6");
    // R10: transfer in live slot is faulted and ignored
    step(encJ(6'b000010, 26'h3FF), 0, 0, 1'b1, "R10");
    step(NOP, 0, 0, 1'b1, "R3");
    // R6: not-equal on equal values is not taken
    step(encI(6'b000101, 5'd1, 5'd2, 16'h0010), 32'h7, 32'h7, 1'b1, "R6");
    step(encR(5'd3, 5'd0, 6'b001000), 32'h4444, 0, 1'b1, "R10");
    // R9: likely equal, not taken -> slot annulled, its jal ignored
    step(encI(6'b010100, 5'd1, 5'd2, 16'h0020), 32'h1, 32'h2, 1'b1, "R9");
    step(encJ(6'b000011, 26'h1234), 0, 0, 1'b1, "R9");
    step(NOP, 0, 0, 1'b1, "R9");
    // R7 / R8: ge-zero with link, not taken on a negative value, still links
    step(encI(6'b000001, 5'd4, 5'b10001, 16'h0040), NEG5, 0, 1'b1, "R8");
    step(NOP, 0, 0, 1'b1, "R7");
    // R7: lt-zero with link and likely, taken
    step(encI(6'b000001, 5'd4, 5'b10010, 16'h0008), NEG5, 0, 1'b1, "R7");
    step(NOP, 0, 0, 1'b1, "R7");
    step(NOP, 0, 0, 1'b1, "R3");
    // R7: ge-zero likely, not taken on -1
    step(encI(6'b000001, 5'd4, 5'b00011, 16'h0008), 32'hFFFF_FFFF, 0, 1'b1, "R7");
    step(NOP, 0, 0, 1'b1, "R9");
    // R7: group member with bits 19:18 set is not a transfer
    step(encI(6'b000001, 5'd4, 5'b01100, 16'h0008), 32'h0, 0, 1'b1, "R7");
    step(encI(6'b000101, 5'd1, 5'd2, 16'h0004), 32'h1, 32'h2, 1'b1, "R7");
    step(NOP, 0, 0, 1'b1, "R6");
    // R5 / R8: linking register jump to high region, link into rd 7
    step(encR(5'd9, 5'd7, 6'b001001), 32'hA000_0000, 0, 1'b1, "R5");
    step(NOP, 0, 0, 1'b1, "R5");
    // R4: absolute jump keeps top nibble
    step(encJ(6'b000010, 26'h123), 0, 0, 1'b1, "R4");
    step(NOP, 0, 0, 1'b1, "R4");
    // R6: zero compares on rs = 0 (le taken, gt not)
    step(encR(5'd9, 5'd0, 6'b001000), 32'h200, 0, 1'b1, "R5");
    step(NOP, 0, 0, 1'b1, "R5");
    step(encI(6'b000111, 5'd1, 5'd0, 16'h0010), 32'h0, 0, 1'b1, "R6");
    step(NOP, 0, 0, 1'b1, "R6");
    step(encI(6'b000110, 5'd1, 5'd0, 16'h0010), 32'h0, 0, 1'b1, "R6");
    step(NOP, 0, 0, 1'b1, "R6");
    // R6: gt-zero likely on large positive, taken -> no annul
    step(encI(6'b010111, 5'd1, 5'd0, 16'h0002), 32'h7FFF_FFFF, 0, 1'b1, "R9");
    step(NOP, 0, 0, 1'b1, "R9");
    step(NOP, 0, 0, 1'b1, "R2");
    step(NOP, 0, 0, 1'b1, "R2");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule